// File: doc/BRIEF.md
# Gate-Pin Fault Protection Sequencer

This block supervises the gate-drive pin of an external high-voltage sensing transistor and decides whether the low-side PWM may run. Analog comparators are outside the block and arrive as digital levels. One says the supply has reached its turn-on level. One says the pin sits below its 12 V low limit. One says the pin is above its 13.8 V over-voltage limit. The block also watches the low-side PWM pulse itself.

After the supply turns on, a timer waits a fixed 10 µs, counted in clock cycles from a clock-frequency parameter. At that instant the pin is sampled once. A pin that is already below the low limit has settled too quickly, which points to an open pin or a capacitor that is too small. In that case switching never starts and the block asks for one forced undervoltage-lockout restart. If the pin passes the check, switching is enabled.

While switching, the block records any over-voltage seen during each PWM pulse and judges it when the pulse ends. Three faulty pulses in a row stop switching and request one restart. Any fault, or a loss of supply, returns the block to idle, where it waits for a fresh supply turn-on.

Top module: `gate_pin_guard`

## Requirements
- R1: During and right after reset, `sw_en` and `uvlo_req` are both 0.
- R2: `pin_low` is sampled only on the clock edge exactly D cycles after the edge that first sees `supply_ok` rise. D = CLK_HZ/1000*CHECK_US/1000, which is 500 at the defaults. When `pin_low` is 0 on that edge, `sw_en` is 1 from that edge on. Before it, `sw_en` stays 0 whatever `pin_low` does.
- R3: When `pin_low` is 1 on the check edge, `sw_en` never rises. `uvlo_req` is 1 for the one cycle after that edge.
- R4: After a forced restart request, the block stays idle with `sw_en` at 0 for as long as `supply_ok` stays high. A new check starts only after `supply_ok` falls and then rises again.
- R5: `pin_ov` counts only while `pwm_lo` is 1. If it is seen high on any cycle of a pulse, that pulse counts as over-voltage. The pulse is judged on the cycle where `pwm_lo` has just returned to 0.
- R6: On the third over-voltage pulse in a row, `sw_en` drops to 0 in the same cycle the pulse ends. `uvlo_req` is 1 for the following cycle.
- R7: A pulse with no over-voltage resets the run of over-voltage pulses to zero.
- R8: When `supply_ok` is 0, `sw_en` is 0 in that same cycle. Both the startup timer and the over-voltage run are cleared.
- R9: `uvlo_req` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above its turn-on level |
| pin_low | input | 1 | Gate pin below the 12 V low limit |
| pin_ov | input | 1 | Gate pin above the 13.8 V over-voltage limit |
| pwm_lo | input | 1 | Low-side PWM pulse, high while on |
| sw_en | output | 1 | Switching may run |
| uvlo_req | output | 1 | One-cycle request for a forced supply restart |

## Verification
A timer that counts wrong moves the startup decision by whole cycles. The bench therefore changes `pin_low` one cycle before the check edge, so a check that is one cycle early or late gives the opposite verdict right at `sw_en` and `uvlo_req`. A run counter that does not clear, or that counts pulses outside RUN, trips too early or too late. That shows up on `sw_en` in the same cycle the deciding pulse ends. A state machine that leaves idle without a fresh supply rise shows up as `sw_en` rising during a long wait after a fault.

// File: rtl/gpg_pkg.sv
package gpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } gpg_state_e;

  // cycles spanned by a delay of us microseconds at clk_hz
  function automatic int unsigned delay_cycles(input int unsigned clk_hz,
                                               input int unsigned us);
    return (clk_hz / 1000) * us / 1000;
  endfunction
endpackage

// File: rtl/gpg_start_timer.sv
module gpg_start_timer #(
  parameter int unsigned DLY = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic chk_now
);
  localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign chk_now = run && (cnt_q == LAST);
endmodule

// File: rtl/gpg_ov_strikes.sv
module gpg_ov_strikes #(
  parameter int unsigned STRIKES = 3,
  localparam int unsigned CW = $clog2(STRIKES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          pwm_lo,
  input  logic          pin_ov,
  output logic          trip,
  output logic [CW-1:0] strikes
);
  localparam logic [CW-1:0] TRIP_AT = CW'(STRIKES - 1);

  logic pwm_q, sticky_q, pulse_end;

  assign pulse_end = pwm_q && !pwm_lo;
  assign trip = arm && pulse_end && sticky_q && (strikes == TRIP_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      strikes  <= '0;
    end else if (!arm) begin
      sticky_q <= 1'b0;
      strikes  <= '0;
    end else begin
      sticky_q <= pwm_lo ? (sticky_q | pin_ov) : 1'b0;
      if (pulse_end) strikes <= sticky_q ? (trip ? '0 : strikes + 1'b1) : '0;
    end
  end
endmodule

// File: rtl/gate_pin_guard.sv
module gate_pin_guard
  import gpg_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned CHECK_US   = 10,
  parameter int unsigned OV_STRIKES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pin_low,
  input  logic pin_ov,
  input  logic pwm_lo,
  output logic sw_en,
  output logic uvlo_req
);
  localparam int unsigned DLY  = delay_cycles(CLK_HZ, CHECK_US);
  localparam int unsigned CNT_W = $clog2(OV_STRIKES + 1);

  gpg_state_e state_q, state_d;
  logic supply_q, supply_rise;
  logic chk_now, start_fail, ov_trip, fault_evt;
  logic [CNT_W-1:0] strike_cnt;

  assign supply_rise = supply_ok && !supply_q;

  gpg_start_timer #(.DLY(DLY)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(state_q == ST_WAIT && supply_ok),
    .chk_now(chk_now)
  );

  gpg_ov_strikes #(.STRIKES(OV_STRIKES)) u_strikes (
    .clk(clk), .rst_n(rst_n),
    .arm(state_q == ST_RUN && supply_ok),
    .pwm_lo(pwm_lo), .pin_ov(pin_ov),
    .trip(ov_trip), .strikes(strike_cnt)
  );

  assign start_fail = chk_now && pin_low;
  assign fault_evt  = start_fail || ov_trip;

  always_comb begin
    state_d = state_q;
    if (!supply_ok) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (supply_rise) state_d = ST_WAIT;
        ST_WAIT: if (chk_now) state_d = pin_low ? ST_IDLE : ST_RUN;
        ST_RUN:  if (ov_trip) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      supply_q <= 1'b0;
      uvlo_req <= 1'b0;
    end else begin
      state_q  <= state_d;
      supply_q <= supply_ok;
      uvlo_req <= fault_evt;
    end
  end

  assign sw_en = (state_q == ST_RUN) && supply_ok && !ov_trip;
endmodule

// File: rtl/gpg_checker.sv
module gpg_checker #(
  parameter int unsigned OV_STRIKES = 3,
  localparam int unsigned CW = $clog2(OV_STRIKES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          pin_low,
  input logic          sw_en,
  input logic          uvlo_req,
  input logic          chk_now,
  input logic [CW-1:0] strike_cnt
);
  // R9
  uvlo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_req |=> !uvlo_req);

  // R8
  en_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> supply_ok);

  // R8
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (strike_cnt == '0 && !sw_en));

  // R2
  en_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(chk_now));

  // R3
  fail_requests_uvlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_now && pin_low) |=> (uvlo_req && !sw_en));

  // R6
  uvlo_blocks_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_req |-> !sw_en);
endmodule

bind gate_pin_guard gpg_checker #(.OV_STRIKES(OV_STRIKES)) u_gpg_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pin_low(pin_low),
  .sw_en(sw_en), .uvlo_req(uvlo_req), .chk_now(chk_now),
  .strike_cnt(strike_cnt)
);

// File: tb/test_gate_pin_guard.sv
module test_gate_pin_guard;
  localparam int CLK_PERIOD = 20;
  localparam int unsigned HZ = 50_000_000;
  localparam int unsigned US = 10;
  localparam int D = (HZ / 1_000_000) * US;  // 500 cycles

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 1'b0, pin_low = 1'b1, pin_ov = 1'b0, pwm_lo = 1'b0;
  logic sw_en, uvlo_req;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_pin_guard #(.CLK_HZ(HZ), .CHECK_US(US), .OV_STRIKES(3)) i_gate_pin_guard (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pin_low(pin_low),
    .pin_ov(pin_ov), .pwm_lo(pwm_lo), .sw_en(sw_en), .uvlo_req(uvlo_req)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // supply rises; pin_low held 1 until the cycle before the check edge
  task automatic startup(bit pass);
    supply_ok = 1'b1; pin_low = 1'b1;
    repeat (D) tick();
    expect1("R2", "sw_en before check", sw_en, 1'b0);
    pin_low = pass ? 1'b0 : 1'b1;
    tick();
    expect1(pass ? "R2" : "R3", "sw_en at check", sw_en, pass);
    expect1("R3", "uvlo_req at check", uvlo_req, !pass);
    pin_low = 1'b1;
    tick();
    expect1("R9", "uvlo_req after one cycle", uvlo_req, 1'b0);
  endtask

  // one PWM pulse of two cycles; returns sw_en seen in the end cycle
  task automatic pulse(bit ov, bit ov_between, output logic en_end);
    pwm_lo = 1'b1; pin_ov = 1'b0; tick();
    pin_ov = ov; tick();
    pwm_lo = 1'b0; pin_ov = ov_between; #1;
    en_end = sw_en;
    tick(); pin_ov = 1'b0; tick();
  endtask

  task automatic power_down();
    supply_ok = 1'b0; #1;
    expect1("R8", "sw_en on supply drop", sw_en, 1'b0);
    repeat (3) tick();
  endtask

  task automatic t_reset();
    expect1("R1", "sw_en in reset", sw_en, 1'b0);
    expect1("R1", "uvlo_req in reset", uvlo_req, 1'b0);
    rst_n = 1'b1; tick();
    expect1("R1", "sw_en after reset", sw_en, 1'b0);
    expect1("R1", "uvlo_req after reset", uvlo_req, 1'b0);
  endtask

  task automatic t_start_fail();
    startup(1'b0);
    pin_low = 1'b0;
    repeat (2 * D) tick();
    expect1("R4", "idle after fault, supply held", sw_en, 1'b0);
    power_down();
  endtask

  task automatic t_ov_runs();
    logic e;
    startup(1'b1);
    pulse(1, 0, e); pulse(1, 0, e); pulse(0, 0, e);
    expect1("R7", "clean pulse resets run", sw_en, 1'b1);
    pulse(1, 0, e); pulse(1, 0, e);
    expect1("R7", "two after clean no trip", sw_en, 1'b1);
    pulse(0, 1, e); pulse(0, 1, e); pulse(0, 1, e);
    expect1("R5", "ov between pulses ignored", sw_en, 1'b1);
    expect1("R5", "no uvlo from ignored ov", uvlo_req, 1'b0);
    pulse(1, 0, e); pulse(1, 0, e);
    expect1("R6", "two strikes still run", sw_en, 1'b1);
    // third strike: check same-cycle drop and next-cycle request
    pwm_lo = 1'b1; tick(); pin_ov = 1'b1; tick(); pin_ov = 1'b0; tick();
    pwm_lo = 1'b0; #1;
    expect1("R6", "sw_en drops as pulse ends", sw_en, 1'b0);
    tick();
    expect1("R6", "uvlo_req after trip", uvlo_req, 1'b1);
    tick();
    expect1("R9", "uvlo_req single", uvlo_req, 1'b0);
    repeat (D + 5) tick();
    expect1("R4", "no restart without new rise", sw_en, 1'b0);
    power_down();
  endtask

  task automatic t_drop_clears();
    logic e;
    startup(1'b1);
    pulse(1, 0, e); pulse(1, 0, e);
    power_down();
    startup(1'b1);
    pulse(1, 0, e);
    expect1("R8", "run cleared by supply drop", sw_en, 1'b1);
    pulse(1, 0, e);
    expect1("R8", "still running after two", sw_en, 1'b1);
    // drop mid-wait, timer must restart
    power_down();
    supply_ok = 1'b1;
    repeat (D / 2) tick();
    supply_ok = 1'b0; tick(); tick();
    startup(1'b1);
    expect1("R8", "running after full restart", sw_en, 1'b1);
    power_down();
  endtask

  initial begin
    #(CLK_PERIOD * 150_000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    t_start_fail();
    t_ov_runs();
    t_drop_clears();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule